// File: doc/BRIEF.md
# Clock Multiplier Enable and Connect Controller

This block sequences an external clock multiplier. Software writes the multiplier and pre-divider codes and the enable, connect and interrupt-enable bits through a small register port. The block decides when the multiplier counts as locked and when the system clock may be switched from the raw input clock to the multiplied clock. It drives one registered select line to an external clock switch and one level interrupt.

Lock comes from one of two sources. While the reference frequency (input clock over the pre-divider) is within the range where the lock indicator can be trusted, the block follows the lock input. When a configuration input flags the reference as out of range, the block ignores the lock input and times a start-up wait instead. That wait is half a millisecond of input-clock cycles, computed from an input-frequency parameter. If a second configuration input flags the reference as below 400 kHz, the wait is 200 reference periods, which is 200 × (pre-divider code + 1) input-clock cycles. The timer is loaded one cycle after the wait restarts and counts from the cycle after that. Lock is therefore reported wait + 1 cycles after the write that restarted it.

Software can enable the multiplier, ask for connection and then carry on with other work. The select line rises by itself once lock arrives, and the interrupt tells software that lock was reached.

Top module: `pll_ctrl_unit`

## Requirements
- R1: After reset every register reads 0, the status word reads 0, and `clk_sel` and `lock_irq` are 0.
- R2: Address 3 returns the status word. The multiplier code is in bits 14:0, the pre-divider code in bits 23:16, enable in bit 24, connect in bit 25 and lock in bit 26. Bits 15 and 31:27 read 0.
- R3: Address 0 holds the 15-bit multiplier code and address 1 the 8-bit pre-divider code. Each code is one less than the actual factor. Address 2 holds enable (bit 0), connect (bit 1) and interrupt enable (bit 2). Writes take effect at once, and unused write bits read back as 0.
- R4: `clk_sel` is 1 only when enable, connect and lock were all 1 at the previous clock edge.
- R5: With enable at 0, a connect request behaves exactly as if both bits were 0. `clk_sel` stays 0, and the lock input has no effect on the lock status.
- R6: A power-down input clears enable and connect at the next edge, keeps interrupt enable, and clears lock. `clk_sel` is 0 from the edge after that.
- R7: While enabled and in range, the lock status follows the lock input one clock later.
- R8: While enabled with the reference out of range and not slow, the lock input is ignored. Lock is reported IN_CLK_KHZ/2 + 1 cycles after the write that started the wait.
- R9: While enabled with the reference out of range and slow, lock is reported 200 × (pre-divider code + 1) + 1 cycles after the write that started the wait.
- R10: A write to the multiplier or the pre-divider, or a control write that changes enable, clears lock at that edge and restarts the wait.
- R11: `lock_irq` is 1 exactly while lock is 1 and interrupt enable is 1.
- R12: A connect request made before lock is held. `clk_sel` rises one cycle after lock without any further write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (reference) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 multiplier, 1 pre-divider, 2 control, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pll_lock_in | input | 1 | Lock indicator from the clock multiplier |
| ref_oor | input | 1 | Reference outside the range where lock is reliable |
| ref_slow | input | 1 | Reference below 400 kHz, meaningful with `ref_oor` |
| pwr_dn | input | 1 | Power-down entry |
| clk_sel | output | 1 | Registered select: 1 multiplied clock, 0 input clock |
| lock_irq | output | 1 | Lock interrupt, level |

## Verification
The assertions check on every cycle that the select line follows enable, connect and lock one edge later. They also check that power-down clears the control bits, that a restart or a disabled multiplier leaves lock at 0, that an out-of-range lock appears only when the timer expires, and that the interrupt rises only with lock and its enable. Only the bench's scenarios can show the exact wait lengths in both out-of-range modes, the register layout and masking, the held connect request completing on lock, and the lock input being ignored when disabled or out of range.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;

  // Field widths fixed by the status word layout
  localparam int MULT_W = 15;
  localparam int PDIV_W = 8;

  typedef enum logic [1:0] {
    REG_MULT = 2'd0,
    REG_PDIV = 2'd1,
    REG_CTRL = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  // Control register bits
  localparam int CT_EN   = 0;
  localparam int CT_CONN = 1;
  localparam int CT_IE   = 2;

  // Status word positions
  localparam int ST_PDIV_LSB = 16;
  localparam int ST_EN_BIT   = 24;
  localparam int ST_CONN_BIT = 25;
  localparam int ST_LOCK_BIT = 26;

  // Half a millisecond of input clock cycles, at least one
  function automatic int unsigned fast_wait_cycles(input int unsigned in_khz);
    int unsigned c;
    c = in_khz / 2;
    return (c == 0) ? 1 : c;
  endfunction

  // 200 reference periods measured in input clock cycles
  function automatic int unsigned slow_wait_cycles(input logic [PDIV_W-1:0] pdiv_code);
    return 200 * (int'(pdiv_code) + 1);
  endfunction

  function automatic logic [31:0] pack_status(
    input logic [MULT_W-1:0] mult,
    input logic [PDIV_W-1:0] pdiv,
    input logic              en,
    input logic              conn,
    input logic              locked
  );
    logic [31:0] s;
    s = '0;
    s[MULT_W-1:0]                    = mult;
    s[ST_PDIV_LSB +: PDIV_W]         = pdiv;
    s[ST_EN_BIT]                     = en;
    s[ST_CONN_BIT]                   = conn;
    s[ST_LOCK_BIT]                   = locked;
    return s;
  endfunction

endpackage

// File: rtl/pll_reg_file.sv
module pll_reg_file
  import pll_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [31:0]       wdata,
  input  logic              pwr_dn,
  output logic [MULT_W-1:0] mult_q,
  output logic [PDIV_W-1:0] pdiv_q,
  output logic              en_q,
  output logic              conn_q,
  output logic              ie_q,
  output logic              restart
);

  logic wr_mult, wr_pdiv, wr_ctrl, en_change;

  assign wr_mult   = wr && (reg_sel_e'(addr) == REG_MULT);
  assign wr_pdiv   = wr && (reg_sel_e'(addr) == REG_PDIV);
  assign wr_ctrl   = wr && (reg_sel_e'(addr) == REG_CTRL);
  assign en_change = wr_ctrl && (wdata[CT_EN] != en_q);

  // Any event that invalidates the present lock
  assign restart = wr_mult || wr_pdiv || en_change || pwr_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q <= '0;
      pdiv_q <= '0;
    end else begin
      if (wr_mult) mult_q <= wdata[MULT_W-1:0];
      if (wr_pdiv) pdiv_q <= wdata[PDIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      conn_q <= 1'b0;
      ie_q   <= 1'b0;
    end else if (pwr_dn) begin
      en_q   <= 1'b0;
      conn_q <= 1'b0;
      if (wr_ctrl) ie_q <= wdata[CT_IE];
    end else if (wr_ctrl) begin
      en_q   <= wdata[CT_EN];
      conn_q <= wdata[CT_CONN];
      ie_q   <= wdata[CT_IE];
    end
  end

endmodule

// File: rtl/pll_lock_tracker.sv
module pll_lock_tracker
  import pll_ctrl_pkg::*;
#(
  parameter int unsigned FAST_WAIT = 6000,
  localparam int unsigned SLOW_MAX = 200 * (2 ** PDIV_W),
  localparam int unsigned CNT_MAX  = (FAST_WAIT > SLOW_MAX) ? FAST_WAIT : SLOW_MAX,
  localparam int         CNT_W     = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              restart,
  input  logic              ref_oor,
  input  logic              ref_slow,
  input  logic [PDIV_W-1:0] pdiv,
  input  logic              lock_in,
  output logic              locked,
  output logic              tmr_last
);

  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic [CNT_W-1:0] load_val;

  assign load_val = ref_slow ? CNT_W'(slow_wait_cycles(pdiv)) : CNT_W'(FAST_WAIT);

  // Last counting cycle of an out-of-range wait
  assign tmr_last = en && !restart && ref_oor && armed && (cnt <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      armed  <= 1'b0;
      cnt    <= '0;
    end else if (!en || restart) begin
      locked <= 1'b0;
      armed  <= 1'b0;
    end else if (!ref_oor) begin
      locked <= lock_in;
    end else if (!armed) begin
      cnt   <= load_val;
      armed <= 1'b1;
    end else begin
      if (tmr_last) locked <= 1'b1;
      if (cnt != '0) cnt <= cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/pll_clk_select.sv
module pll_clk_select (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic conn,
  input  logic locked,
  output logic sel
);

  logic use_pll;
  assign use_pll = en && conn && locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel <= 1'b0;
    else        sel <= use_pll;
  end

endmodule

// File: rtl/pll_ctrl_unit.sv
module pll_ctrl_unit
  import pll_ctrl_pkg::*;
#(
  parameter int unsigned IN_CLK_KHZ = 12000,
  localparam int unsigned FAST_WAIT = fast_wait_cycles(IN_CLK_KHZ)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        pll_lock_in,
  input  logic        ref_oor,
  input  logic        ref_slow,
  input  logic        pwr_dn,
  output logic        clk_sel,
  output logic        lock_irq
);

  logic [MULT_W-1:0] mult_q;
  logic [PDIV_W-1:0] pdiv_q;
  logic              en_q, conn_q, ie_q, restart;
  logic              locked_q, tmr_last;

  pll_reg_file u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .pwr_dn (pwr_dn),
    .mult_q (mult_q),
    .pdiv_q (pdiv_q),
    .en_q   (en_q),
    .conn_q (conn_q),
    .ie_q   (ie_q),
    .restart(restart)
  );

  pll_lock_tracker #(.FAST_WAIT(FAST_WAIT)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_q),
    .restart (restart),
    .ref_oor (ref_oor),
    .ref_slow(ref_slow),
    .pdiv    (pdiv_q),
    .lock_in (pll_lock_in),
    .locked  (locked_q),
    .tmr_last(tmr_last)
  );

  pll_clk_select u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_q),
    .conn  (conn_q),
    .locked(locked_q),
    .sel   (clk_sel)
  );

  assign lock_irq = locked_q && ie_q;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel_e'(reg_addr))
      REG_MULT: reg_rdata[MULT_W-1:0] = mult_q;
      REG_PDIV: reg_rdata[PDIV_W-1:0] = pdiv_q;
      REG_CTRL: begin
        reg_rdata[CT_EN]   = en_q;
        reg_rdata[CT_CONN] = conn_q;
        reg_rdata[CT_IE]   = ie_q;
      end
      REG_STAT: reg_rdata = pack_status(mult_q, pdiv_q, en_q, conn_q, locked_q);
    endcase
  end

endmodule

// File: rtl/pll_ctrl_unit_chk.sv
module pll_ctrl_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_dn,
  input logic ref_oor,
  input logic clk_sel,
  input logic lock_irq,
  input logic en_q,
  input logic conn_q,
  input logic ie_q,
  input logic locked_q,
  input logic restart,
  input logic tmr_last
);

  // R4
  sel_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && conn_q && locked_q) |=> clk_sel);

  // R4
  sel_needs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_q && conn_q && locked_q) |=> !clk_sel);

  // R6
  pd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!en_q && !conn_q && !locked_q));

  // R6
  pd_sel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> ##2 !clk_sel);

  // R10
  restart_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !locked_q);

  // R5
  off_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !locked_q);

  // R8
  oor_timer_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(locked_q) && $past(ref_oor)) |-> $past(tmr_last));

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_irq) |-> (locked_q && ie_q));

endmodule

bind pll_ctrl_unit pll_ctrl_unit_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pwr_dn  (pwr_dn),
  .ref_oor (ref_oor),
  .clk_sel (clk_sel),
  .lock_irq(lock_irq),
  .en_q    (en_q),
  .conn_q  (conn_q),
  .ie_q    (ie_q),
  .locked_q(locked_q),
  .restart (restart),
  .tmr_last(tmr_last)
);

// File: tb/pll_ctrl_unit_bench.sv
module pll_ctrl_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int KHZ        = 40;
  localparam int FAST_W     = KHZ / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pll_lock_in = 1'b0;
  logic        ref_oor = 1'b0;
  logic        ref_slow = 1'b0;
  logic        pwr_dn = 1'b0;
  logic        clk_sel, lock_irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_ctrl_unit #(.IN_CLK_KHZ(KHZ)) u_pll_ctrl_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pll_lock_in(pll_lock_in),
    .ref_oor(ref_oor), .ref_slow(ref_slow), .pwr_dn(pwr_dn),
    .clk_sel(clk_sel), .lock_irq(lock_irq)
  );

  // Register vectors: address, write data, expected read-back (R3)
  localparam int NV = 8;
  localparam logic [1:0]  V_ADDR [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd2};
  localparam logic [31:0] V_DATA [NV] = '{32'h0000_7FFF, 32'hFFFF_2345, 32'h0000_0000,
                                          32'h0000_00FF, 32'h0000_01A5, 32'h0000_0004,
                                          32'hFFFF_FFF8, 32'h0000_0002};
  localparam logic [31:0] V_EXP  [NV] = '{32'h0000_7FFF, 32'h0000_2345, 32'h0000_0000,
                                          32'h0000_00FF, 32'h0000_00A5, 32'h0000_0004,
                                          32'h0000_0000, 32'h0000_0002};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic lock_bit(output logic b);
    logic [31:0] s;
    rd(2'd3, s);
    b = s[26];
  endtask

  // Counts negedges after a write until status lock reads 1
  task automatic wait_lock(output int k);
    logic b;
    k = 0;
    lock_bit(b);
    while (!b && k < 5000) begin
      @(negedge clk);
      k++;
      lock_bit(b);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        b;
    int          k;

    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reg", d, 32'h0);
    end
    check("R1 clk_sel", {31'd0, clk_sel}, 32'd0);
    check("R1 irq", {31'd0, lock_irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 register table
    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_DATA[i]);
      rd(V_ADDR[i], d);
      check("R3 readback", d, V_EXP[i]);
    end

    // R2 status layout (connect=1 left by table, enable 0)
    wr(2'd0, 32'h0000_1234);
    wr(2'd1, 32'h0000_0056);
    rd(2'd3, d);
    check("R2 status", d, 32'h0256_1234);

    // R5 connect without enable, lock input high
    pll_lock_in = 1'b1;
    repeat (3) @(negedge clk);
    lock_bit(b);
    check("R5 no lock", {31'd0, b}, 32'd0);
    check("R5 clk_sel", {31'd0, clk_sel}, 32'd0);
    pll_lock_in = 1'b0;

    // R12 pending connect, R7 follow, R11 irq, R4 select
    wr(2'd2, 32'h7);
    repeat (3) @(negedge clk);
    lock_bit(b);
    check("R7 unlocked", {31'd0, b}, 32'd0);
    check("R12 held", {31'd0, clk_sel}, 32'd0);
    pll_lock_in = 1'b1;
    @(negedge clk);
    lock_bit(b);
    check("R7 lock", {31'd0, b}, 32'd1);
    check("R11 irq on", {31'd0, lock_irq}, 32'd1);
    check("R4 sel one later", {31'd0, clk_sel}, 32'd0);
    @(negedge clk);
    check("R12 sel on", {31'd0, clk_sel}, 32'd1);
    rd(2'd3, d);
    check("R2 status full", d, 32'h0756_1234);

    // R11 irq enable off
    wr(2'd2, 32'h3);
    check("R11 irq masked", {31'd0, lock_irq}, 32'd0);
    wr(2'd2, 32'h7);

    // R10 multiplier write restarts
    wr(2'd0, 32'h0000_0010);
    lock_bit(b);
    check("R10 cleared", {31'd0, b}, 32'd0);
    check("R4 sel still", {31'd0, clk_sel}, 32'd1);
    @(negedge clk);
    check("R4 sel drop", {31'd0, clk_sel}, 32'd0);
    lock_bit(b);
    check("R7 relock", {31'd0, b}, 32'd1);
    pll_lock_in = 1'b0;
    @(negedge clk);
    lock_bit(b);
    check("R7 lock lost", {31'd0, b}, 32'd0);
    pll_lock_in = 1'b1;
    repeat (2) @(negedge clk);

    // R6 power-down
    pwr_dn = 1'b1;
    @(negedge clk);
    pwr_dn = 1'b0;
    rd(2'd2, d);
    check("R6 ctrl", d, 32'h4);
    lock_bit(b);
    check("R6 lock", {31'd0, b}, 32'd0);
    @(negedge clk);
    check("R6 sel", {31'd0, clk_sel}, 32'd0);
    repeat (2) @(negedge clk);
    lock_bit(b);
    check("R5 off ignores lock", {31'd0, b}, 32'd0);

    // R8 out of range, fast wait; lock input held high and ignored
    ref_oor = 1'b1;
    wr(2'd2, 32'h1);
    wait_lock(k);
    check("R8 wait", 32'(k), 32'(FAST_W + 1));

    // R10 pre-divider write restarts the timer
    wr(2'd1, 32'h0000_0056);
    lock_bit(b);
    check("R10 oor cleared", {31'd0, b}, 32'd0);
    wait_lock(k);
    check("R10 rewait", 32'(k), 32'(FAST_W + 1));

    // R9 slow reference: 200*(code+1)
    wr(2'd2, 32'h0);
    ref_slow = 1'b1;
    wr(2'd1, 32'h0000_0001);
    wr(2'd2, 32'h1);
    wait_lock(k);
    check("R9 wait", 32'(k), 32'(200 * 2 + 1));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule